// File: doc/BRIEF.md
# Wait-Instruction Standby Clock Controller

This block sits beside a processor core and decides whether the core's internal clocks stop when a wait instruction retires, and when they start again. When the retirement pulse arrives and the system bus is idle in that same cycle, the controller drops its core clock enable. When the bus is busy in that cycle, it rejects the wait, flags it as a no-op and leaves the clocks running. Every retiring wait that the block considers also asks the core to turn its interrupts on.

While the core is asleep, the controller keeps watching the six maskable interrupt lines and their enables, the non-maskable interrupt and the internal timer interrupt. Any of these sources wakes the core. A soft reset or a cold reset sends the block back to the running state at once. The PLL, the timer and the clock-gating cell are outside this block. It only produces the enable and the state changes.

Top module: `standby_clk_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, clk_en_o is 1, wait_nop_o is 0 and int_en_set_o is 0.
- R2: A wait_retire_i pulse is a qualifying wait when the core is running, bus_idle_i is 1, no wake source is active and no reset input is high. After a qualifying wait, clk_en_o is 0 from the next cycle.
- R3: A wait_retire_i pulse with bus_idle_i at 0, while the core is running and no reset input is high, makes wait_nop_o 1 for exactly the next cycle. clk_en_o stays 1.
- R4: While asleep and with no wake source active, clk_en_o stays 0. A wait_retire_i pulse while asleep has no effect on any output.
- R5: While asleep, a maskable interrupt line irq_i[i] that is high while irq_en_i[i] is 1 makes clk_en_o 1 from the next cycle. This holds for each of the six lines.
- R6: A maskable interrupt line whose enable bit irq_en_i[i] is 0 does not wake the core.
- R7: nmi_i or timer_irq_i, when high while asleep, makes clk_en_o 1 from the next cycle. Neither depends on irq_en_i.
- R8: When soft_rst_i or cold_rst_i is high, clk_en_o is 1 in that same cycle without waiting for a clock edge. The block is in the running state after the edge. A wait_retire_i pulse in that cycle is ignored: no sleep, no no-op pulse and no interrupt-enable pulse.
- R9: A wait that retires with the bus idle while a wake source is already active does not put the core to sleep and does not produce a no-op pulse.
- R10: Each wait_retire_i pulse taken while running and not in reset makes int_en_set_o 1 for exactly the next cycle, whether or not the wait is a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| soft_rst_i | input | 1 | Soft reset request, active high |
| cold_rst_i | input | 1 | Cold reset request, active high |
| wait_retire_i | input | 1 | Pulse: a wait instruction finished writeback |
| bus_idle_i | input | 1 | System bus is idle |
| irq_i | input | 6 | Maskable interrupt lines |
| irq_en_i | input | 6 | Per-line interrupt enables |
| nmi_i | input | 1 | Non-maskable interrupt |
| timer_irq_i | input | 1 | Internal timer interrupt |
| clk_en_o | output | 1 | Core clock enable |
| wait_nop_o | output | 1 | One-cycle pulse: the wait was treated as a no-op |
| int_en_set_o | output | 1 | One-cycle pulse: set the core's interrupt enable |

## Verification
The assertions assume that wait_retire_i is a single-cycle pulse. They also assume that a retirement pulse never arrives while the core is asleep, except as a deliberate probe of R4. The sleep-hold and gating properties allow a reset input that rises in the following cycle. The stimulus drives every input once per cycle at the falling edge. It spaces retirement pulses at least one idle cycle apart and holds wake sources for single cycles only. The one exception is the R9 case, where a wake source is deliberately kept active while the wait retires.

// File: rtl/standby_pkg.sv
package standby_pkg;
  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_SLEEP = 1'b1
  } sb_state_e;

  localparam int unsigned SB_N_IRQ = 6;
endpackage

// File: rtl/sb_wake_detect.sv
module sb_wake_detect #(
  parameter int unsigned N_IRQ = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             nmi_i,
  input  logic             timer_irq_i,
  output logic             wake_o
);
  logic [N_IRQ-1:0] line_live;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    assign line_live[g] = irq_i[g] & irq_en_i[g];
  end

  assign wake_o = (|line_live) | nmi_i | timer_irq_i;

  // nmi and timer ignore mask
  assert_unmasked_wake_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i || timer_irq_i) |-> wake_o);
  assert_masked_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nmi_i && !timer_irq_i && ((irq_i & irq_en_i) == '0)) |-> !wake_o);
endmodule

// File: rtl/sb_wait_qual.sv
module sb_wait_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_retire_i,
  input  logic bus_idle_i,
  input  logic running_i,
  input  logic wake_i,
  input  logic rst_req_i,
  output logic enter_o,
  output logic wait_nop_o,
  output logic int_en_set_o
);
  logic taken;
  logic reject;
  logic nop_q;
  logic ie_q;

  assign taken   = wait_retire_i & running_i & ~rst_req_i;
  assign enter_o = taken & bus_idle_i & ~wake_i;
  assign reject  = taken & ~bus_idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nop_q <= 1'b0;
      ie_q  <= 1'b0;
    end else begin
      nop_q <= reject;
      ie_q  <= taken;
    end
  end

  assign wait_nop_o   = nop_q;
  assign int_en_set_o = ie_q;

  assert_nop_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_nop_o |-> $past(wait_retire_i && !bus_idle_i));
  assert_nop_follows_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_retire_i && running_i && !bus_idle_i && !rst_req_i) |=> wait_nop_o);
  assert_ie_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_en_set_o |-> $past(wait_retire_i));
endmodule

// File: rtl/sb_state_ctrl.sv
module sb_state_ctrl
  import standby_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic wake_i,
  input  logic rst_req_i,
  output logic running_o,
  output logic clk_en_o
);
  sb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (rst_req_i)                              state_d = ST_RUN;
    else if (state_q == ST_RUN && enter_i)      state_d = ST_SLEEP;
    else if (state_q == ST_SLEEP && wake_i)     state_d = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign running_o = (state_q == ST_RUN);
  // reset request overrides the gate without waiting for an edge
  assign clk_en_o  = running_o | rst_req_i;

  assert_rst_override_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |-> clk_en_o);
  assert_wake_restores_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && wake_i) |=> clk_en_o);
  assert_sleep_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_o && !wake_i) |=> (!clk_en_o || rst_req_i));
  assert_gate_after_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_i |=> (!clk_en_o || rst_req_i));
endmodule

// File: rtl/standby_clk_ctrl.sv
module standby_clk_ctrl
  import standby_pkg::*;
#(
  parameter int unsigned N_IRQ = SB_N_IRQ
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             cold_rst_i,
  input  logic             wait_retire_i,
  input  logic             bus_idle_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             nmi_i,
  input  logic             timer_irq_i,
  output logic             clk_en_o,
  output logic             wait_nop_o,
  output logic             int_en_set_o
);
  logic rst_req;
  logic wake;
  logic enter;
  logic running;

  assign rst_req = soft_rst_i | cold_rst_i;

  sb_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_i       (irq_i),
    .irq_en_i    (irq_en_i),
    .nmi_i       (nmi_i),
    .timer_irq_i (timer_irq_i),
    .wake_o      (wake)
  );

  sb_wait_qual u_qual (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wait_retire_i (wait_retire_i),
    .bus_idle_i    (bus_idle_i),
    .running_i     (running),
    .wake_i        (wake),
    .rst_req_i     (rst_req),
    .enter_o       (enter),
    .wait_nop_o    (wait_nop_o),
    .int_en_set_o  (int_en_set_o)
  );

  sb_state_ctrl u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enter_i   (enter),
    .wake_i    (wake),
    .rst_req_i (rst_req),
    .running_o (running),
    .clk_en_o  (clk_en_o)
  );

  assert_pending_wake_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && wait_retire_i && bus_idle_i && wake && !rst_req) |=> (clk_en_o && !wait_nop_o));
endmodule

// File: tb/standby_clk_ctrl_tb.sv
module standby_clk_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       soft_rst_i = 1'b0, cold_rst_i = 1'b0;
  logic       wait_retire_i = 1'b0, bus_idle_i = 1'b1;
  logic [5:0] irq_i = '0, irq_en_i = '0;
  logic       nmi_i = 1'b0, timer_irq_i = 1'b0;
  logic       clk_en_o, wait_nop_o, int_en_set_o;

  int n_run = 0, n_fail = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  standby_clk_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .cold_rst_i(cold_rst_i),
    .wait_retire_i(wait_retire_i), .bus_idle_i(bus_idle_i), .irq_i(irq_i),
    .irq_en_i(irq_en_i), .nmi_i(nmi_i), .timer_irq_i(timer_irq_i),
    .clk_en_o(clk_en_o), .wait_nop_o(wait_nop_o), .int_en_set_o(int_en_set_o)
  );

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {clk_en,nop,ie} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: compares outputs after each rising edge
  always @(posedge clk_i) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {clk_en_o, wait_nop_o, int_en_set_o}, e);
    end
  end

  // driver: one cycle of stimulus plus the expected outputs after its edge
  task automatic step(input string tag, input logic wr, input logic idle,
                      input logic [5:0] irq, input logic [5:0] en, input logic nmi,
                      input logic tmr, input logic srst, input logic crst,
                      input logic [2:0] exp);
    @(negedge clk_i);
    wait_retire_i = wr; bus_idle_i = idle; irq_i = irq; irq_en_i = en;
    nmi_i = nmi; timer_irq_i = tmr; soft_rst_i = srst; cold_rst_i = crst;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle_step(input string tag, input logic [2:0] exp);
    step(tag, 0, 1, '0, 6'h3f, 0, 0, 0, 0, exp);
  endtask

  task automatic go_sleep(input string tag);
    step(tag, 1, 1, '0, 6'h3f, 0, 0, 0, 0, 3'b001);
    idle_step(tag, 3'b000);
  endtask

  initial begin
    #8000000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 in reset", {clk_en_o, wait_nop_o, int_en_set_o}, 3'b100);
    rst_ni = 1'b1;
    idle_step("R1 after release", 3'b100);
    // R2 entry, R10 pulse
    go_sleep("R2 qualifying wait");
    idle_step("R4 hold asleep", 3'b000);
    step("R4 wait while asleep", 1, 0, '0, 6'h3f, 0, 0, 0, 0, 3'b000);
    step("R6 masked line", 0, 1, 6'h01, 6'h3e, 0, 0, 0, 0, 3'b000);
    step("R5 irq2 wake", 0, 1, 6'h04, 6'h3f, 0, 0, 0, 0, 3'b100);
    idle_step("R5 stays running", 3'b100);
    // R3 busy bus
    step("R3 busy wait", 1, 0, '0, 6'h3f, 0, 0, 0, 0, 3'b111);
    idle_step("R3 single pulse", 3'b100);
    // R7
    go_sleep("R7 nmi setup");
    step("R7 nmi wake", 0, 1, '0, 6'h00, 1, 0, 0, 0, 3'b100);
    go_sleep("R7 timer setup");
    step("R7 timer wake", 0, 1, '0, 6'h00, 0, 1, 0, 0, 3'b100);
    // R5 each line
    for (int i = 0; i < 6; i++) begin
      go_sleep("R5 line setup");
      step("R5 per-line wake", 0, 1, 6'(1 << i), 6'(1 << i), 0, 0, 0, 0, 3'b100);
    end
    // R8 immediate override
    go_sleep("R8 setup");
    @(negedge clk_i);
    cold_rst_i = 1'b1;
    #1;
    check("R8 same-cycle cold reset", {clk_en_o, wait_nop_o, int_en_set_o}, 3'b100);
    exp_q.push_back(3'b100); tag_q.push_back("R8 cold reset edge");
    idle_step("R8 running after cold reset", 3'b100);
    step("R8 wait during soft reset", 1, 1, '0, 6'h3f, 0, 0, 1, 0, 3'b100);
    idle_step("R8 wait ignored", 3'b100);
    go_sleep("R8 soft setup");
    step("R8 soft reset wake", 0, 1, '0, 6'h3f, 0, 0, 1, 0, 3'b100);
    idle_step("R8 running after soft reset", 3'b100);
    // R9 pending wake
    step("R9 wait with nmi pending", 1, 1, '0, 6'h3f, 1, 0, 0, 0, 3'b101);
    idle_step("R9 still running", 3'b100);
    idle_step("drain", 3'b100);
    @(negedge clk_i);
    @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule